// File: doc/BRIEF.md
# Two-Clock Mux-D Scan Chain with Boundary Lock-Up Latch

This block is one scan chain whose storage cells belong to two clock domains. The `N1` cells clocked by `clkA` come first in the chain, and the `N2` cells clocked by `clkB` follow them. Each cell has a multiplexer in front of it. In functional mode (`scanEnable` low) every cell loads its own bit of the parallel functional input. In shift mode (`scanEnable` high) the cells form one serial path from `scanIn` to `scanOut`, so a pattern can be loaded and unloaded bit by bit.

The path crosses from one domain to the other at a single point. A level-sensitive lock-up latch sits there. The latch is open only while `clkA` is low, so it holds the last `clkA` cell's value for half a `clkA` period after that cell's launching edge. If `clkB` arrives late, the first `clkB` cell still takes the value the last `clkA` cell held before the shared edge, and not the value that cell loaded on that edge.

The parameter `LOCKUP_EN` selects the variant at build time. With the default of 1 the latch is present. With 0 the two domains are joined by a wire, which exposes the slippage the latch prevents.

Top module: `dual_domain_scan_chain`

## Requirements
- R1: While `rstN` is low, every cell and the lock-up latch are cleared, so `funcOutA`, `funcOutB` and `scanOut` all read 0.
- R2: With `scanEnable` low, each `clkA` rising edge loads `funcInA` into the `clkA` cells and each `clkB` rising edge loads `funcInB` into the `clkB` cells. `funcOutA[i]` and `funcOutB[i]` show cell i of their domain.
- R3: With `scanEnable` high, cell 0 of domain A takes `scanIn` and cell i takes cell i-1. Cell 0 of domain B takes the boundary stage, and `scanOut` is the last domain-B cell. A bit presented before shift edge k appears on `scanOut` before edge k+N1+N2.
- R4: The lock-up latch is transparent while `clkA` is low and holds while `clkA` is high. An `N1+N2`-bit pattern therefore passes through the chain unchanged and in order when `clkB` lags `clkA` by less than half a period.
- R5: After one capture edge per domain, shifting unloads `funcInB[N2-1]` down to `funcInB[0]`, then `funcInA[N1-1]` down to `funcInA[0]`.
- R6: A chain-integrity flush with the repeating pattern 0,0,1,1 is shifted right after reset and comes out intact, before any capture pattern is used.
- R7: With `LOCKUP_EN` = 0 and `clkB` lagging `clkA`, the first domain-B cell takes the value just launched by the last domain-A cell. One bit is lost and the flushed pattern comes out wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Clock of the leading chain segment |
| clkB | input | 1 | Clock of the trailing chain segment |
| rstN | input | 1 | Asynchronous reset, active low |
| scanEnable | input | 1 | 1 = shift, 0 = functional capture |
| scanIn | input | 1 | Serial input to domain-A cell 0 |
| scanOut | output | 1 | Last domain-B cell |
| funcInA | input | N1 | Functional inputs of the domain-A cells |
| funcOutA | output | N1 | Domain-A cell contents |
| funcInB | input | N2 | Functional inputs of the domain-B cells |
| funcOutB | output | N2 | Domain-B cell contents |

## Verification
The hardest situation to reach is the hold race at the domain boundary. With ideal clocks both domains update in the same time step and no slippage can ever show. The bench therefore drives `clkB` as a copy of `clkA` delayed by a fixed skew, so the domain-B edge lands after the domain-A cells have already changed. It runs the same flush through two instances, one with the latch and one without, and requires the first to be exact and the second to be corrupted.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;
  // Per-domain path select strobes from the control to the datapath.
  typedef struct packed {
    logic shiftA;
    logic shiftB;
  } scan_strobe_t;
endpackage

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_chain_pkg::*;
(
  input  logic         scanEnable,
  output scan_strobe_t strobe
);
  // Both segments follow the same mode pin; each is sampled by its own clock.
  always_comb begin
    strobe.shiftA = scanEnable;
    strobe.shiftB = scanEnable;
  end
endmodule

// File: rtl/scan_segment.sv
module scan_segment #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftSel,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] funcIn,
  output logic [WIDTH-1:0] cells
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_cell
      logic prevBit;
      if (i == 0) begin : g_head
        assign prevBit = serialIn;
      end else begin : g_body
        assign prevBit = cells[i-1];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cells[i] <= 1'b0;
        else       cells[i] <= shiftSel ? prevBit : funcIn[i];
      end
    end
  endgenerate

  // R3: a shift edge moves the whole segment by one place toward the output.
  assert_shift_moves_R3: assert property (@(posedge clk) disable iff (!rstN)
    shiftSel |=> cells == WIDTH'({$past(cells), $past(serialIn)}));

  // R2: a capture edge loads the parallel inputs.
  assert_capture_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    !shiftSel |=> cells == $past(funcIn));

  // R1: the first edge after reset release still sees cleared cells.
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> cells == '0);
endmodule

// File: rtl/lockup_stage.sv
module lockup_stage #(
  parameter bit ENABLE = 1'b1
) (
  input  logic launchClk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (ENABLE) begin : g_latch
      logic heldQ;
      // Open during the low phase of the launching clock only.
      always_latch begin
        if (!rstN)          heldQ <= 1'b0;
        else if (!launchClk) heldQ <= d;
      end
      assign q = heldQ;

      // R4: when the launching edge arrives the latch carries the pre-edge value.
      assert_latch_holds_old_R4: assert property (@(posedge launchClk) disable iff (!rstN)
        heldQ == d);
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dual_domain_scan_chain.sv
module dual_domain_scan_chain
  import scan_chain_pkg::*;
#(
  parameter int N1        = 4,
  parameter int N2        = 4,
  parameter bit LOCKUP_EN = 1'b1
) (
  input  logic          clkA,
  input  logic          clkB,
  input  logic          rstN,
  input  logic          scanEnable,
  input  logic          scanIn,
  output logic          scanOut,
  input  logic [N1-1:0] funcInA,
  output logic [N1-1:0] funcOutA,
  input  logic [N2-1:0] funcInB,
  output logic [N2-1:0] funcOutB
);
  scan_strobe_t strobe;
  logic boundaryBit;

  scan_chain_ctrl u_ctrl (
    .scanEnable(scanEnable),
    .strobe    (strobe)
  );

  scan_segment #(.WIDTH(N1)) u_segA (
    .clk     (clkA),
    .rstN    (rstN),
    .shiftSel(strobe.shiftA),
    .serialIn(scanIn),
    .funcIn  (funcInA),
    .cells   (funcOutA)
  );

  lockup_stage #(.ENABLE(LOCKUP_EN)) u_lockup (
    .launchClk(clkA),
    .rstN     (rstN),
    .d        (funcOutA[N1-1]),
    .q        (boundaryBit)
  );

  scan_segment #(.WIDTH(N2)) u_segB (
    .clk     (clkB),
    .rstN    (rstN),
    .shiftSel(strobe.shiftB),
    .serialIn(boundaryBit),
    .funcIn  (funcInB),
    .cells   (funcOutB)
  );

  assign scanOut = funcOutB[N2-1];
endmodule

// File: tb/tb_dual_domain_scan_chain.sv
module tb_dual_domain_scan_chain;
  localparam int N1 = 4;
  localparam int N2 = 4;
  localparam int L = N1 + N2;
  localparam int SKEW = 2;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic scanEnable = 1'b0, scanIn = 1'b0;
  logic [N1-1:0] funcInA = '0;
  logic [N2-1:0] funcInB = '0;
  logic scanOut, scanOutBy;
  logic [N1-1:0] funcOutA, funcOutABy;
  logic [N2-1:0] funcOutB, funcOutBBy;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clkA = ~clkA;
  always @(clkA) clkB <= #SKEW clkA;

  dual_domain_scan_chain #(.N1(N1), .N2(N2), .LOCKUP_EN(1'b1)) dut (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .scanEnable(scanEnable), .scanIn(scanIn),
    .scanOut(scanOut), .funcInA(funcInA), .funcOutA(funcOutA),
    .funcInB(funcInB), .funcOutB(funcOutB));

  dual_domain_scan_chain #(.N1(N1), .N2(N2), .LOCKUP_EN(1'b0)) dutBypass (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .scanEnable(scanEnable), .scanIn(scanIn),
    .scanOut(scanOutBy), .funcInA(funcInA), .funcOutA(funcOutABy),
    .funcInB(funcInB), .funcOutB(funcOutBBy));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    @(negedge clkA);
    check("R1 funcOutA in reset", 32'(funcOutA), 0);
    check("R1 funcOutB in reset", 32'(funcOutB), 0);
    check("R1 scanOut in reset", 32'(scanOut), 0);
    rstN = 1'b1;
    @(negedge clkA);
  endtask

  // Loads pat (bit 0 first), then unloads with zeros; returns bypass mismatches.
  task automatic flush(string req, logic [L-1:0] pat, output int bypassBad);
    bypassBad = 0;
    scanEnable = 1'b1;
    for (int k = 0; k < L; k++) begin
      scanIn = pat[k];
      @(negedge clkA);
    end
    for (int j = 0; j < L; j++) begin
      check(req, 32'(scanOut), 32'(pat[j]));
      if (scanOutBy !== pat[j]) bypassBad++;
      scanIn = 1'b0;
      @(negedge clkA);
    end
  endtask

  task automatic testIntegrity();
    int bad;
    flush("R6 R4 chain-integrity flush", 8'b1100_1100, bad);
    // R7: without the latch the lagging clock lets a bit slip
    checks++;
    if (bad == 0) begin
      failures++;
      $display("FAIL R7 bypass mismatches actual=%0d expected=nonzero", bad);
    end
  endtask

  task automatic testPattern();
    int bad;
    flush("R3 serial order", 8'b1011_0001, bad);
  endtask

  task automatic testCapture();
    scanEnable = 1'b0;
    funcInA = 4'b1010;
    funcInB = 4'b0110;
    @(negedge clkA);
    check("R2 funcOutA capture", 32'(funcOutA), 32'(funcInA));
    check("R2 funcOutB capture", 32'(funcOutB), 32'(funcInB));
    check("R2 bypass funcOutB capture", 32'(funcOutBBy), 32'(funcInB));
    scanEnable = 1'b1;
    scanIn = 1'b0;
    for (int j = 0; j < L; j++) begin
      logic exp;
      exp = (j < N2) ? funcInB[N2-1-j] : funcInA[N1-1-(j-N2)];
      check("R5 unload order", 32'(scanOut), 32'(exp));
      @(negedge clkA);
    end
  endtask

  task automatic testMidReset();
    scanEnable = 1'b1;
    scanIn = 1'b1;
    for (int k = 0; k < L; k++) @(negedge clkA);
    check("R3 ones reached scanOut", 32'(scanOut), 1);
    rstN = 1'b0;
    #1;
    check("R1 funcOutA after async reset", 32'(funcOutA), 0);
    check("R1 funcOutB after async reset", 32'(funcOutB), 0);
    check("R1 scanOut after async reset", 32'(scanOut), 0);
    scanIn = 1'b0;
    @(negedge clkA);
    rstN = 1'b1;
    @(negedge clkA);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clkA);
    testReset();
    testIntegrity();
    testPattern();
    testCapture();
    testMidReset();
    testIntegrity();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule